// File: doc/BRIEF.md
# Transmit Fail-Safe Timeout Supervisor

This block keeps a runaway transmitter off the serial bus. It counts 12 MHz clock cycles while the encoder reports transmit activity. A message is an unbroken stretch of activity, so back-to-back words count as one message. The count restarts whenever the encoder goes idle. If a message is still active after 768 µs (9216 cycles), the block raises a sticky fail-safe flag. It also drives a transmit-inhibit line that stops the encoder at once and keeps it from starting again.

The flag and the inhibit stay set until one of two things happens: the master reset is pulled low, or the decoder reports a valid command word carrying this terminal's address. While master reset is low, the inhibit line is held high, so the encoder stays quiet during reset. The threshold is derived from two parameters, the clock rate in MHz and the limit in microseconds.

Top module: `tx_failsafe_sup`

## Requirements
- R1: While `mrst_n` is low, `fs_flag` is 0 and `tx_inhibit` is 1, whatever the other inputs do; this takes effect without waiting for a clock edge. Once `mrst_n` has been high for one clock edge with the flag clear, `tx_inhibit` is 0.
- R2: A message of at most 9216 consecutive rising edges with `tx_active` high never sets `fs_flag`.
- R3: `fs_flag` goes to 1 on the 9217th consecutive rising edge at which `tx_active` is sampled high, and not on any earlier edge.
- R4: `tx_inhibit` is 1 in every cycle in which `fs_flag` is 1.
- R5: A single edge with `tx_active` low restarts the timer. Two messages of 9000 edges each, separated by one idle edge, do not set the flag.
- R6: Once set, `fs_flag` stays 1 while `cmd_ok` is low, whether `tx_active` is high or low.
- R7: An edge with `cmd_ok` high and `fs_flag` set clears both `fs_flag` and `tx_inhibit` at that edge.
- R8: If the timeout and `cmd_ok` fall on the same edge, the timeout wins and `fs_flag` is 1 after that edge.
- R9: While the flag is set, the timer holds at zero. After a clear with `tx_active` still high, the flag sets again exactly 9217 active edges after the clearing edge.
- R10: `cmd_ok` pulsed while the flag is clear does not restart the timer. 5000 active edges, one edge with `cmd_ok`, then more active edges still trip at the 9217th active edge in total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 12 MHz block clock |
| mrst_n | input | 1 | Master reset, active low, asynchronous |
| tx_active | input | 1 | High while the encoder is sending any part of a message |
| cmd_ok | input | 1 | One-cycle pulse from the decoder on a valid command addressed to this terminal |
| fs_flag | output | 1 | Fail-safe flag, sticky, high after a timeout |
| tx_inhibit | output | 1 | Stops and blocks the encoder; high on timeout and during reset |

## Verification
The bench probes the threshold from both sides: exactly 9216 active edges with no flag, and 9217 with the flag. An off-by-one compare would either trip the legal message or let the runaway message run one cycle too long. A one-edge idle gap between two long messages catches a timer that fails to restart between words. It also runs the cases where a clear and a timeout land on the same edge, where a command arrives while the flag is clear, and where activity continues through a clear. A design that gave the clear priority, let a command restart the timer, or kept counting while inhibited would trip at the wrong edge or not at all.

// File: rtl/fs_sup_pkg.sv
package fs_sup_pkg;

  typedef enum logic [1:0] {
    LAT_HOLD = 2'd0,
    LAT_SET  = 2'd1,
    LAT_CLR  = 2'd2
  } lat_op_e;

  // Cycle count that a message may last without tripping.
  function automatic int unsigned limit_cycles(int unsigned mhz, int unsigned usec);
    return mhz * usec;
  endfunction

  // Counter width able to hold the limit value itself.
  function automatic int unsigned count_width(int unsigned lim);
    return (lim < 2) ? 1 : $clog2(lim + 1);
  endfunction

  // A timeout outranks a clear request on the same edge.
  function automatic lat_op_e latch_op(logic set_req, logic clr_req);
    if (set_req)      return LAT_SET;
    else if (clr_req) return LAT_CLR;
    else              return LAT_HOLD;
  endfunction

endpackage

// File: rtl/fs_msg_timer.sv
module fs_msg_timer #(
  parameter int unsigned LIMIT = 9216,
  parameter int unsigned CNT_W = 14
) (
  input  logic             clk,
  input  logic             mrst_n,
  input  logic             tx_active,
  input  logic             hold_zero,
  output logic             trip,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] LIM_V = CNT_W'(LIMIT);

  logic at_limit;

  assign at_limit = (count == LIM_V);
  assign trip     = tx_active & ~hold_zero & at_limit;

  always_ff @(posedge clk or negedge mrst_n) begin
    if (!mrst_n) begin
      count <= '0;
    end else if (hold_zero || !tx_active || at_limit) begin
      count <= '0;
    end else begin
      count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/fs_flag_latch.sv
module fs_flag_latch
  import fs_sup_pkg::*;
(
  input  logic clk,
  input  logic mrst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  lat_op_e op;

  assign op = latch_op(set_i, clr_i);

  always_ff @(posedge clk or negedge mrst_n) begin
    if (!mrst_n) begin
      flag_o <= 1'b0;
    end else begin
      case (op)
        LAT_SET: flag_o <= 1'b1;
        LAT_CLR: flag_o <= 1'b0;
        default: flag_o <= flag_o;
      endcase
    end
  end

endmodule

// File: rtl/tx_failsafe_sup.sv
module tx_failsafe_sup
  import fs_sup_pkg::*;
#(
  parameter int unsigned CLK_MHZ  = 12,
  parameter int unsigned LIMIT_US = 768
) (
  input  logic clk,
  input  logic mrst_n,
  input  logic tx_active,
  input  logic cmd_ok,
  output logic fs_flag,
  output logic tx_inhibit
);

  localparam int unsigned LIMIT_CYC = limit_cycles(CLK_MHZ, LIMIT_US);
  localparam int unsigned CNT_W     = count_width(LIMIT_CYC);

  logic             trip_evt;
  logic [CNT_W-1:0] cnt_q;

  fs_msg_timer #(
    .LIMIT (LIMIT_CYC),
    .CNT_W (CNT_W)
  ) u_timer (
    .clk       (clk),
    .mrst_n    (mrst_n),
    .tx_active (tx_active),
    .hold_zero (fs_flag),
    .trip      (trip_evt),
    .count     (cnt_q)
  );

  fs_flag_latch u_flag (
    .clk    (clk),
    .mrst_n (mrst_n),
    .set_i  (trip_evt),
    .clr_i  (cmd_ok),
    .flag_o (fs_flag)
  );

  assign tx_inhibit = fs_flag | ~mrst_n;

endmodule

// File: rtl/fs_sup_chk.sv
module fs_sup_chk #(
  parameter int unsigned LIMIT = 9216,
  parameter int unsigned CNT_W = 14
) (
  input logic             clk,
  input logic             mrst_n,
  input logic             tx_active,
  input logic             cmd_ok,
  input logic             fs_flag,
  input logic             tx_inhibit,
  input logic             trip_evt,
  input logic [CNT_W-1:0] cnt_q
);

  AST_RST_STATE: assert property (@(posedge clk)
    !mrst_n |-> (!fs_flag && tx_inhibit)); // R1

  AST_INH_WITH_FLAG: assert property (@(posedge clk) disable iff (!mrst_n)
    fs_flag |-> tx_inhibit); // R4

  AST_TRIP_SETS: assert property (@(posedge clk) disable iff (!mrst_n)
    trip_evt |=> fs_flag); // R3

  AST_RISE_NEEDS_TX: assert property (@(posedge clk) disable iff (!mrst_n)
    $rose(fs_flag) |-> $past(tx_active)); // R2

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!mrst_n)
    (fs_flag && !cmd_ok) |=> fs_flag); // R6

  AST_CMD_CLEARS: assert property (@(posedge clk) disable iff (!mrst_n)
    (fs_flag && cmd_ok && !trip_evt) |=> !fs_flag); // R7

  AST_IDLE_RESTART: assert property (@(posedge clk) disable iff (!mrst_n)
    !tx_active |=> (cnt_q == '0)); // R5

  AST_HOLD_WHILE_SET: assert property (@(posedge clk) disable iff (!mrst_n)
    fs_flag |=> (cnt_q == '0)); // R9

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!mrst_n)
    cnt_q <= CNT_W'(LIMIT)); // R3

endmodule

bind tx_failsafe_sup fs_sup_chk #(
  .LIMIT (LIMIT_CYC),
  .CNT_W (CNT_W)
) u_fs_sup_chk (
  .clk        (clk),
  .mrst_n     (mrst_n),
  .tx_active  (tx_active),
  .cmd_ok     (cmd_ok),
  .fs_flag    (fs_flag),
  .tx_inhibit (tx_inhibit),
  .trip_evt   (trip_evt),
  .cnt_q      (cnt_q)
);

// File: tb/tb_tx_failsafe_sup.sv
`timescale 1ns/1ps
module tb_tx_failsafe_sup;

  localparam int unsigned LIM = 12 * 768;

  logic clk = 1'b0;
  logic mrst_n = 1'b0;
  logic tx_active = 1'b0;
  logic cmd_ok = 1'b0;
  logic fs_flag;
  logic tx_inhibit;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tx_failsafe_sup dut (
    .clk        (clk),
    .mrst_n     (mrst_n),
    .tx_active  (tx_active),
    .cmd_ok     (cmd_ok),
    .fs_flag    (fs_flag),
    .tx_inhibit (tx_inhibit)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    tx_active = 1'b0;
    cmd_ok    = 1'b0;
    mrst_n    = 1'b0;
    edges(3);
    chk("R1 flag in reset", fs_flag, 1'b0);
    chk("R1 inhibit in reset", tx_inhibit, 1'b1);
    mrst_n = 1'b1;
    edges(1);
    chk("R1 inhibit after release", tx_inhibit, 1'b0);
  endtask

  task automatic t_limit_exact();
    do_reset();
    tx_active = 1'b1;
    edges(LIM);
    chk("R2 flag at 9216 edges", fs_flag, 1'b0);
    tx_active = 1'b0;
    edges(5);
    chk("R2 flag after legal message", fs_flag, 1'b0);
    chk("R2 inhibit after legal message", tx_inhibit, 1'b0);
  endtask

  task automatic t_trip();
    do_reset();
    tx_active = 1'b1;
    edges(LIM);
    chk("R3 no flag before 9217th edge", fs_flag, 1'b0);
    edges(1);
    chk("R3 flag at 9217th edge", fs_flag, 1'b1);
    chk("R4 inhibit with flag", tx_inhibit, 1'b1);
  endtask

  task automatic t_gap();
    do_reset();
    tx_active = 1'b1;
    edges(9000);
    tx_active = 1'b0;
    edges(1);
    tx_active = 1'b1;
    edges(9000);
    chk("R5 no flag after gap", fs_flag, 1'b0);
    tx_active = 1'b0;
    edges(1);
  endtask

  task automatic t_sticky_clear();
    t_trip();
    edges(100);
    chk("R6 flag holds with tx high", fs_flag, 1'b1);
    tx_active = 1'b0;
    edges(50);
    chk("R6 flag holds with tx idle", fs_flag, 1'b1);
    chk("R4 inhibit holds", tx_inhibit, 1'b1);
    cmd_ok = 1'b1;
    edges(1);
    cmd_ok = 1'b0;
    chk("R7 flag cleared by command", fs_flag, 1'b0);
    chk("R7 inhibit cleared by command", tx_inhibit, 1'b0);
  endtask

  task automatic t_retrip_after_clear();
    t_trip();
    edges(20);
    cmd_ok = 1'b1;
    edges(1);
    cmd_ok = 1'b0;
    chk("R9 cleared with tx still high", fs_flag, 1'b0);
    edges(LIM);
    chk("R9 no flag at 9216 after clear", fs_flag, 1'b0);
    edges(1);
    chk("R9 flag at 9217 after clear", fs_flag, 1'b1);
  endtask

  task automatic t_same_edge();
    do_reset();
    tx_active = 1'b1;
    edges(LIM);
    cmd_ok = 1'b1;
    edges(1);
    cmd_ok = 1'b0;
    chk("R8 timeout beats clear", fs_flag, 1'b1);
  endtask

  task automatic t_cmd_no_restart();
    do_reset();
    tx_active = 1'b1;
    edges(5000);
    cmd_ok = 1'b1;
    edges(1);
    cmd_ok = 1'b0;
    edges(LIM - 5001);
    chk("R10 no flag at 9216 total", fs_flag, 1'b0);
    edges(1);
    chk("R10 flag at 9217 total", fs_flag, 1'b1);
  endtask

  task automatic t_reset_mid_flag();
    t_trip();
    #3;
    mrst_n = 1'b0;
    #2;
    chk("R1 async clear of flag", fs_flag, 1'b0);
    chk("R1 inhibit during reset", tx_inhibit, 1'b1);
    tx_active = 1'b0;
    edges(2);
    mrst_n = 1'b1;
    edges(1);
    chk("R1 idle after reset", tx_inhibit, 1'b0);
  endtask

  initial begin
    t_limit_exact();
    t_trip();
    t_gap();
    t_sticky_clear();
    t_retrip_after_clear();
    t_same_edge();
    t_cmd_no_restart();
    t_reset_mid_flag();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule